// File: doc/BRIEF.md
# Debug Halt Entry Sequencer

This block takes a small CPU core out of normal execution and parks it in a halted debug state. Two triggers can start the entry: a request from the host debug port and a breakpoint-match pulse. Either one starts the same fixed chain of one-cycle steps:

1. Hold off the next program fetch.
2. Hand the return address to the stack.
3. Save the memory-page bit, then clear it.
4. Force the instruction pointer to a fixed service vector.
5. Clear the global interrupt enable.
6. Stop the core.

Timer and watchdog clocks are frozen for as long as debug is active. A return request issued while halted restores the saved page bit, asks the stack to pop the return address and hands control back to the program.

The return address leaves the block on a valid/ready stream: `push_valid` with `push_data`. `push_valid` rises in the push step and stays high, with `push_data` unchanged, until a cycle in which `push_ready` is high. The sequence does not advance while the stack holds `push_ready` low. All other pins are plain control and status levels or pulses.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset the sequencer is idle.
  - `dbg_status` is 2'b00 and `cpu_halt` is 0.
  - `tmr_clk_en` is 1.
  - `fetch_block`, `push_valid`, `pop_req`, `page_we`, `ip_we` and `ige_clr_we` are 0.
- R2: A high `host_dbg_req` sampled at a clock edge while idle starts entry.
  - The following cycles are, one each: a block cycle (`fetch_block`=1), the push cycle(s), a page cycle, an instruction-pointer cycle, an interrupt-enable cycle, and then the halted state.
- R3: A high `bkpt_hit` sampled while idle starts exactly the same sequence as a host request.
- R4: In the push step, `push_valid` is 1 and `push_data` equals the `cur_ip` value sampled with the trigger. While `push_ready` is 0, `push_valid` and `push_data` hold and the sequence waits.
- R5: In the page step, `page_we`=1 with `page_wdata`=0, and the value of `page_bit_in` is saved. On return, `page_we`=1 with `page_wdata` equal to the saved value.
- R6: In the instruction-pointer step, `ip_we`=1 and `ip_wdata` is the fixed vector 16'h8010.
- R7: In the interrupt-enable step, `ige_clr_we` is 1 only when `ige_in` is 1. It is 0 in every other cycle.
- R8: In the halted state, `cpu_halt`=1 and `dbg_status`=2'b01 (ready for commands). At all other times `cpu_halt`=0 and `dbg_status`=2'b00.
- R9: Triggers that arrive while entry is in progress or the core is halted are ignored: no second push and no restart of the sequence.
- R10: `tmr_clk_en` is 0 from the block cycle until the return cycle, inclusive. Otherwise it is 1.
- R11: Both triggers high in the same cycle cause a single entry.
- R12: `ret_req` while halted pulses `pop_req` for that cycle and returns the sequencer to idle at the next edge. `ret_req` at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_dbg_req | input | 1 | Debug request from the host port |
| bkpt_hit | input | 1 | Breakpoint match pulse |
| ret_req | input | 1 | Return-to-program request |
| cur_ip | input | ADDR_W | Address to resume at |
| page_bit_in | input | 1 | Current memory-page bit of the core |
| ige_in | input | 1 | Current global interrupt enable |
| push_ready | input | 1 | Stack accepts the return address |
| fetch_block | output | 1 | Suppress program fetch |
| push_valid | output | 1 | Return address offered to the stack |
| push_data | output | ADDR_W | Return address |
| pop_req | output | 1 | Pop the return address (return cycle) |
| page_we | output | 1 | Write strobe for the page bit |
| page_wdata | output | 1 | Page bit value to write |
| ip_we | output | 1 | Instruction pointer write strobe |
| ip_wdata | output | ADDR_W | Instruction pointer write value |
| ige_clr_we | output | 1 | Clear the global interrupt enable |
| cpu_halt | output | 1 | Core halted |
| tmr_clk_en | output | 1 | Timer and watchdog clock enable |
| dbg_status | output | 2 | 00 running, 01 debug idle |

## Verification
Entry is started in four ways: by the host request, by the breakpoint, by both together, and by a trigger held high across the whole sequence. Comparing these separates "one entry per trigger event" from a design that restarts or pushes twice. The push handshake is run both without stalls and with several cycles of back-pressure, which shows whether data and step order hold while waiting. Page and interrupt-enable values of both polarities show that the saved page bit comes back on return and that the interrupt clear fires only when the enable was set. A stray return request while idle confirms it has no effect.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BLOCK  = 3'd1,
    ST_PUSH   = 3'd2,
    ST_PAGE   = 3'd3,
    ST_LOADIP = 3'd4,
    ST_CLRIGE = 3'd5,
    ST_HALTED = 3'd6
  } dbg_state_e;

  localparam logic [1:0] STAT_RUN  = 2'b00;
  localparam logic [1:0] STAT_IDLE = 2'b01;
endpackage

// File: rtl/dbg_trig_merge.sv
module dbg_trig_merge #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              host_req,
  input  logic              bkpt_hit,
  input  logic [ADDR_W-1:0] cur_ip,
  output logic              start,
  output logic [ADDR_W-1:0] ret_addr
);
  // Either source, or both at once, makes one start event while armed.
  assign start = armed && (host_req || bkpt_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ret_addr <= '0;
    else if (start) ret_addr <= cur_ip;
  end

  // R9: once disarmed, the captured return address is not overwritten.
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(ret_addr));
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       push_ready,
  input  logic       ret_req,
  output dbg_state_e state
);
  dbg_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = ST_BLOCK;
      ST_BLOCK:  nxt = ST_PUSH;
      ST_PUSH:   if (push_ready) nxt = ST_PAGE;
      ST_PAGE:   nxt = ST_LOADIP;
      ST_LOADIP: nxt = ST_CLRIGE;
      ST_CLRIGE: nxt = ST_HALTED;
      ST_HALTED: if (ret_req) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else state <= nxt;
  end

  // R2: fixed step order
  a_r2_block_to_push: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_BLOCK |=> state == ST_PUSH);
  a_r2_page_to_ip: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PAGE |=> state == ST_LOADIP);
  a_r2_ip_to_ige: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_LOADIP |=> state == ST_CLRIGE);
  // R9: no restart while active
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_IDLE |=> state != ST_BLOCK);
  // R12: return goes straight back to idle
  a_r12_return: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALTED && ret_req) |=> state == ST_IDLE);
endmodule

// File: rtl/dbg_ctx_save.sv
module dbg_ctx_save (
  input  logic clk,
  input  logic rst_n,
  input  logic save_en,
  input  logic page_in,
  output logic saved_page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) saved_page <= 1'b0;
    else if (save_en) saved_page <= page_in;
  end

  // R5: the saved bit only moves in the save step
  a_r5_save_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !save_en |=> $stable(saved_page));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VECTOR = 16'h8010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_dbg_req,
  input  logic              bkpt_hit,
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] cur_ip,
  input  logic              page_bit_in,
  input  logic              ige_in,
  input  logic              push_ready,
  output logic              fetch_block,
  output logic              push_valid,
  output logic [ADDR_W-1:0] push_data,
  output logic              pop_req,
  output logic              page_we,
  output logic              page_wdata,
  output logic              ip_we,
  output logic [ADDR_W-1:0] ip_wdata,
  output logic              ige_clr_we,
  output logic              cpu_halt,
  output logic              tmr_clk_en,
  output logic [1:0]        dbg_status
);
  dbg_state_e        state;
  logic              start;
  logic              armed;
  logic              saved_page;
  logic              returning;
  logic [ADDR_W-1:0] ret_addr;

  assign armed = (state == ST_IDLE);

  dbg_trig_merge #(.ADDR_W(ADDR_W)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .host_req (host_dbg_req),
    .bkpt_hit (bkpt_hit),
    .cur_ip   (cur_ip),
    .start    (start),
    .ret_addr (ret_addr)
  );

  dbg_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .push_ready (push_ready),
    .ret_req    (ret_req),
    .state      (state)
  );

  dbg_ctx_save u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_en    (state == ST_PAGE),
    .page_in    (page_bit_in),
    .saved_page (saved_page)
  );

  assign returning   = (state == ST_HALTED) && ret_req;
  assign fetch_block = !armed;
  assign push_valid  = (state == ST_PUSH);
  assign push_data   = ret_addr;
  assign pop_req     = returning;
  assign page_we     = (state == ST_PAGE) || returning;
  assign page_wdata  = returning ? saved_page : 1'b0;
  assign ip_we       = (state == ST_LOADIP);
  assign ip_wdata    = VECTOR;
  assign ige_clr_we  = (state == ST_CLRIGE) && ige_in;
  assign cpu_halt    = (state == ST_HALTED);
  assign tmr_clk_en  = armed;
  assign dbg_status  = cpu_halt ? STAT_IDLE : STAT_RUN;

  // R4: back-pressure holds the offered address
  a_r4_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));
  // R7: interrupt enable is only cleared when it was set
  a_r7_ige_cond: assert property (@(posedge clk) disable iff (!rst_n)
    ige_clr_we |-> ige_in);
  // R10: timers frozen while the stack is being written
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid || cpu_halt) |-> !tmr_clk_en);
  // R8: halted implies ready status
  a_r8_status: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> dbg_status == 2'b01);
  // R12: pop comes with page restore and only while halted
  a_r12_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |-> (page_we && cpu_halt));
  // R6: vector write happens right after the page step
  a_r6_ip_order: assert property (@(posedge clk) disable iff (!rst_n)
    (page_we && !pop_req) |=> ip_we);
endmodule

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
  localparam int AW = 16;
  localparam logic [AW-1:0] VEC = 16'h8010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_dbg_req = 0, bkpt_hit = 0, ret_req = 0;
  logic [AW-1:0] cur_ip = '0;
  logic page_bit_in = 0, ige_in = 0, push_ready = 1;
  logic fetch_block, push_valid, pop_req, page_we, page_wdata, ip_we;
  logic ige_clr_we, cpu_halt, tmr_clk_en;
  logic [AW-1:0] push_data, ip_wdata;
  logic [1:0] dbg_status;

  int checks = 0;
  int errors = 0;
  int pushes = 0;
  bit done = 0;
  logic [AW-1:0] exp_push_q[$];
  logic exp_page_q[$];

  always #4 clk = ~clk;

  dbg_entry_ctrl #(.ADDR_W(AW), .VECTOR(VEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_dbg_req(host_dbg_req), .bkpt_hit(bkpt_hit),
    .ret_req(ret_req), .cur_ip(cur_ip), .page_bit_in(page_bit_in), .ige_in(ige_in),
    .push_ready(push_ready), .fetch_block(fetch_block), .push_valid(push_valid),
    .push_data(push_data), .pop_req(pop_req), .page_we(page_we), .page_wdata(page_wdata),
    .ip_we(ip_we), .ip_wdata(ip_wdata), .ige_clr_we(ige_clr_we), .cpu_halt(cpu_halt),
    .tmr_clk_en(tmr_clk_en), .dbg_status(dbg_status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares stream handshakes and page restores with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && push_valid && push_ready) begin
        pushes++;
        if (exp_push_q.size() == 0)
          chk(0, "R9", "unexpected push", {16'h0, push_data}, 32'h0);
        else begin
          logic [AW-1:0] e;
          e = exp_push_q.pop_front();
          chk(push_data == e, "R4", "push_data", {16'h0, push_data}, {16'h0, e});
        end
      end
      if (rst_n && pop_req) begin
        if (exp_page_q.size() == 0)
          chk(0, "R12", "unexpected pop", 32'h1, 32'h0);
        else begin
          logic e;
          e = exp_page_q.pop_front();
          chk(page_we && page_wdata == e, "R5", "restored page",
              {31'h0, page_wdata}, {31'h0, e});
        end
      end
    end
  end

  task automatic enter(input bit h, input bit b, input logic [AW-1:0] ip,
                       input bit pg, input bit ige, input int stall, input bit hold);
    int p0;
    string rq;
    rq = b && !h ? "R3" : "R2";
    p0 = pushes;
    @(negedge clk);
    host_dbg_req = h; bkpt_hit = b; cur_ip = ip; page_bit_in = pg; ige_in = ige;
    push_ready = (stall == 0);
    exp_push_q.push_back(ip);
    exp_page_q.push_back(pg);
    @(negedge clk);
    if (!hold) begin host_dbg_req = 0; bkpt_hit = 0; end
    cur_ip = ~ip;
    #1;
    chk(fetch_block && !push_valid, rq, "block step", {31'h0, fetch_block}, 32'h1);
    chk(!tmr_clk_en, "R10", "timer gated in block step", {31'h0, tmr_clk_en}, 32'h0);
    @(negedge clk);
    #1;
    chk(push_valid, "R4", "push_valid", {31'h0, push_valid}, 32'h1);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      #1;
      chk(push_valid && push_data == ip && !page_we, "R4", "stalled push",
          {16'h0, push_data}, {16'h0, ip});
    end
    push_ready = 1;
    @(negedge clk);
    #1;
    chk(page_we && !page_wdata && !push_valid, "R5", "page clear",
        {30'h0, page_we, page_wdata}, 32'h2);
    @(negedge clk);
    #1;
    chk(ip_we && ip_wdata == VEC, "R6", "vector write", {15'h0, ip_we, ip_wdata},
        {15'h0, 1'b1, VEC});
    @(negedge clk);
    #1;
    chk(ige_clr_we == ige, "R7", "ige clear", {31'h0, ige_clr_we}, {31'h0, ige});
    @(negedge clk);
    #1;
    chk(cpu_halt && dbg_status == 2'b01, "R8", "halted status", {30'h0, dbg_status}, 32'h1);
    chk(pushes - p0 == 1, (h && b) ? "R11" : "R9", "push count",
        pushes - p0, 32'h1);
    host_dbg_req = 0; bkpt_hit = 0;
  endtask

  task automatic leave;
    @(negedge clk);
    ret_req = 1;
    #1;
    chk(pop_req && !tmr_clk_en, "R12", "pop pulse", {31'h0, pop_req}, 32'h1);
    @(negedge clk);
    ret_req = 0;
    #1;
    chk(!cpu_halt && dbg_status == 2'b00 && !fetch_block && !pop_req, "R12",
        "back to idle", {30'h0, dbg_status}, 32'h0);
    chk(tmr_clk_en, "R10", "timer released", {31'h0, tmr_clk_en}, 32'h1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(dbg_status == 2'b00 && !cpu_halt && tmr_clk_en && !fetch_block && !push_valid
        && !ip_we && !page_we && !ige_clr_we && !pop_req, "R1", "reset state",
        {30'h0, dbg_status}, 32'h0);
    rst_n = 1;

    // R2 host entry, no stall, page 1, ige 1
    enter(1, 0, 16'h1234, 1, 1, 0, 0);
    // R9 retrigger while halted
    @(negedge clk);
    host_dbg_req = 1; bkpt_hit = 1;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(cpu_halt && !push_valid && fetch_block, "R9", "retrigger ignored",
          {31'h0, cpu_halt}, 32'h1);
    end
    host_dbg_req = 0; bkpt_hit = 0;
    leave();

    // R3 breakpoint entry, back-pressure, page 0, ige 0
    enter(0, 1, 16'hA5C3, 0, 0, 3, 0);
    leave();

    // R11 both triggers together
    enter(1, 1, 16'h0F0F, 1, 0, 1, 0);
    leave();

    // R9 trigger held high through the whole sequence
    enter(1, 0, 16'h7FFE, 0, 1, 2, 1);
    leave();

    // R12 stray return request while idle
    @(negedge clk);
    ret_req = 1;
    #1;
    chk(!pop_req && !page_we, "R12", "idle return ignored", {31'h0, pop_req}, 32'h0);
    @(negedge clk);
    ret_req = 0;
    #1;
    chk(dbg_status == 2'b00 && !fetch_block && tmr_clk_en, "R12", "still idle",
        {31'h0, fetch_block}, 32'h0);

    repeat (2) @(negedge clk);
    chk(exp_push_q.size() == 0 && exp_page_q.size() == 0, "R4", "scoreboard drained",
        exp_push_q.size(), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule